// File: doc/BRIEF.md
# Glitch-free clock source selector

This block picks one of two clock sources and drives it onto a single clock output. The two sources may have no phase or frequency relation at all. When the select input changes, the output is not cut over at once. The path that is leaving finishes its current pulse, and the output then rests at its idle level. The path that is arriving is let through only after it has seen that the leaving path is off. Because of this, the output never shows a high or low phase shorter than the shortest phase of either source.

A static parameter sets the polarity. In the rising-edge variant the output idles low, and each path's enable changes while its own clock is low. In the falling-edge variant both roles are inverted: the output idles high, and the enables change while their clocks are high. In both variants a select of 0 picks source 0 and a select of 1 picks source 1.

After a change, the select must be held steady until the handover has finished. That takes a few cycles of each source.

Top module: `clkmux_glitchless`

## Requirements
- R1: With select held at 0, the output carries source 0 (same period and same phase levels), once any handover has finished.
- R2: With select held at 1, the output carries source 1, once any handover has finished.
- R3: Every output high phase and every output low phase is at least as long as the shortest high or low phase of either source. This holds across switchovers made at arbitrary times.
- R4: During a handover, the output rests at its idle level (low in the rising-edge variant) for longer than any natural phase of either source. The two paths are never enabled at the same time.
- R5: A select pulse that starts and ends inside the active phase of the currently selected clock has no effect. The output keeps following that clock.
- R6: While reset is active and directly after it is released, source 0 is enabled and source 1 is disabled, so the output follows source 0.
- R7: With the falling-edge variant selected, the output idles high, select keeps the same meaning, and R1 to R3 hold with the levels swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0_i | input | 1 | Clock source 0, chosen when select is 0 |
| clk1_i | input | 1 | Clock source 1, chosen when select is 1 |
| sel_i | input | 1 | Source select. It may be asynchronous to both sources |
| rst_ni | input | 1 | Asynchronous active-low reset. Its release is synchronised separately in each source's domain |
| clk_o | output | 1 | Selected clock. It rests at the idle level while a handover is in progress |

## Verification
The hardest case to reach from the ports is a select pulse that falls entirely inside the active phase of the selected clock and never reaches one of that clock's sampling edges. The bench anchors each such pulse to an edge of the selected source and releases it a fraction of a phase later. It then checks the output level in the middle of several following phases. A second hard case is a switchover that races the phases of both sources. For this, select is flipped after random delays at fractional-nanosecond offsets against two sources whose period ratio is not an integer, and every output phase is measured against the minimum width.

// File: rtl/clkmux_pkg.sv
`timescale 1ns/1ps
package clkmux_pkg;

  // Polarity of the selector: which level the output rests at between pulses.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_mode_e;

  // Number of selectable sources; the handover scheme is built for two.
  localparam int unsigned NUM_SRC = 2;

  // Minimum depth of any synchroniser chain in this block.
  localparam int unsigned MIN_STAGES = 2;

endpackage

// File: rtl/clkmux_rst_sync.sv
`timescale 1ns/1ps
// Reset release synchroniser: assertion is asynchronous, release follows
// STAGES edges of the local clock.
module clkmux_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] pipe_d;
  logic [STAGES-1:0] pipe_q;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_no = pipe_q[STAGES-1];

endmodule

// File: rtl/clkmux_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchroniser with a selectable reset value.
module clkmux_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  localparam logic [STAGES-1:0] RST_WORD = {STAGES{RST_VAL}};

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= RST_WORD;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkmux_leg.sv
`timescale 1ns/1ps
// One source path: decides whether its source may reach the output.
// All state is clocked on the source's inactive edge, so the enable only
// moves while the source sits at the idle level.
module clkmux_leg #(
  parameter int unsigned STAGES      = 2,
  parameter logic        ON_AT_RESET = 1'b0
) (
  input  logic clk_inact_i,
  input  logic arst_ni,
  input  logic want_i,
  input  logic peer_en_i,
  output logic en_o
);

  logic leg_rst_n;
  logic grant_req;

  clkmux_rst_sync #(
    .STAGES (STAGES)
  ) u_rst (
    .clk_i   (clk_inact_i),
    .arst_ni (arst_ni),
    .rst_no  (leg_rst_n)
  );

  // Request only while the other path is seen off.
  always_comb begin
    grant_req = want_i & ~peer_en_i;
  end

  clkmux_sync #(
    .STAGES  (STAGES),
    .RST_VAL (ON_AT_RESET)
  ) u_sync (
    .clk_i  (clk_inact_i),
    .rst_ni (leg_rst_n),
    .d_i    (grant_req),
    .q_o    (en_o)
  );

endmodule

// File: rtl/clkmux_gate.sv
`timescale 1ns/1ps
// Output combiner: OR of each source's active phase gated by its enable,
// turned back to the chosen polarity.
module clkmux_gate
  import clkmux_pkg::*;
#(
  parameter int unsigned N    = 2,
  parameter edge_mode_e  EDGE = EDGE_RISE
) (
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] en_i,
  output logic         clk_o
);

  localparam logic IDLE_LVL = (EDGE == EDGE_FALL);

  logic [N-1:0] pass;

  for (genvar g = 0; g < N; g++) begin : g_pass
    assign pass[g] = act_i[g] & en_i[g];
  end

  assign clk_o = (|pass) ^ IDLE_LVL;

endmodule

// File: rtl/clkmux_glitchless.sv
`timescale 1ns/1ps
module clkmux_glitchless
  import clkmux_pkg::*;
#(
  parameter edge_mode_e  EDGE        = EDGE_RISE,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic sel_i,
  input  logic rst_ni,
  output logic clk_o
);

  localparam logic IDLE_LVL = (EDGE == EDGE_FALL);
  localparam int unsigned DEPTH = (SYNC_STAGES < MIN_STAGES) ? MIN_STAGES : SYNC_STAGES;

  logic [NUM_SRC-1:0] src;
  logic [NUM_SRC-1:0] act;
  logic [NUM_SRC-1:0] inact;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] en;

  assign src  = {clk1_i, clk0_i};
  assign want = {sel_i, ~sel_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_leg
    // act is high during the phase the output should pass through
    assign act[g]   = src[g] ^ IDLE_LVL;
    assign inact[g] = ~act[g];

    clkmux_leg #(
      .STAGES      (DEPTH),
      .ON_AT_RESET (g == 0)
    ) u_leg (
      .clk_inact_i (inact[g]),
      .arst_ni     (rst_ni),
      .want_i      (want[g]),
      .peer_en_i   (en[NUM_SRC-1-g]),
      .en_o        (en[g])
    );
  end

  clkmux_gate #(
    .N    (NUM_SRC),
    .EDGE (EDGE)
  ) u_gate (
    .act_i (act),
    .en_i  (en),
    .clk_o (clk_o)
  );

endmodule

// File: rtl/clkmux_checker.sv
`timescale 1ns/1ps
module clkmux_checker
  import clkmux_pkg::*;
#(
  parameter edge_mode_e EDGE = EDGE_RISE
) (
  input logic [1:0] act_i,
  input logic [1:0] en_i,
  input logic       clk_o,
  input logic       rst_ni
);

  localparam logic IDLE_LVL = (EDGE == EDGE_FALL);

  AST_EXCLUSIVE_EN: assert property (@(posedge act_i[0]) disable iff (!rst_ni) $onehot0(en_i)) else $error("both paths enabled"); // R4

  AST_HANDOFF_AFTER_OFF: assert property (@(posedge act_i[1]) disable iff (!rst_ni) $rose(en_i[1]) |-> $past(!en_i[0])) else $error("path 1 on before path 0 off"); // R4

  AST_PARK_IDLE: assert property (@(negedge act_i[1]) disable iff (!rst_ni) (!en_i[0] && !en_i[1]) |-> (clk_o == IDLE_LVL)) else $error("output not parked"); // R4

  AST_PASS_SRC0: assert property (@(negedge act_i[0]) disable iff (!rst_ni) en_i[0] |-> (clk_o != IDLE_LVL)) else $error("source 0 pulse lost"); // R1

  AST_PASS_SRC1: assert property (@(negedge act_i[1]) disable iff (!rst_ni) en_i[1] |-> (clk_o != IDLE_LVL)) else $error("source 1 pulse lost"); // R2

endmodule

bind clkmux_glitchless clkmux_checker #(.EDGE(EDGE)) u_chk (
  .act_i  (act),
  .en_i   (en),
  .clk_o  (clk_o),
  .rst_ni (rst_ni)
);

// File: tb/tb_clkmux_glitchless.sv
`timescale 1ns/1ps
module tb_clkmux_glitchless;
  import clkmux_pkg::*;

  localparam int CLK_PERIOD  = 10;
  localparam int CLK1_PERIOD = 14;
  localparam int MIN_PHASE   = 5;
  localparam int MAX_NAT     = 7;
  localparam int SETTLE      = 120;

  logic clk0 = 1'b0;
  logic clk1 = 1'b0;
  logic sel = 1'b0;
  logic rst_n = 1'b0;
  logic out_r;
  logic out_f;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  int max_idle_r = 0;
  int max_idle_f = 0;
  time last_rise_r = 0, last_fall_r = 0, last_rise_f = 0, last_fall_f = 0;

  typedef struct {
    bit    fall;
    int    period;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk0 = ~clk0;
  always #(CLK1_PERIOD/2) clk1 = ~clk1;

  clkmux_glitchless #(.EDGE(EDGE_RISE)) dut (
    .clk0_i (clk0), .clk1_i (clk1), .sel_i (sel), .rst_ni (rst_n), .clk_o (out_r)
  );

  clkmux_glitchless #(.EDGE(EDGE_FALL)) dut_fall (
    .clk0_i (clk0), .clk1_i (clk1), .sel_i (sel), .rst_ni (rst_n), .clk_o (out_f)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Phase monitors: every completed phase is measured (R3, R7)
  always @(posedge out_r) begin
    int w;
    w = int'($time - last_fall_r);
    if (armed) begin
      check(w >= MIN_PHASE, "R3 low phase width", w, MIN_PHASE);
      if (w > max_idle_r) max_idle_r = w;
    end
    last_rise_r = $time;
  end

  always @(negedge out_r) begin
    int w;
    w = int'($time - last_rise_r);
    if (armed) check(w >= MIN_PHASE, "R3 high phase width", w, MIN_PHASE);
    last_fall_r = $time;
  end

  always @(negedge out_f) begin
    int w;
    w = int'($time - last_rise_f);
    if (armed) begin
      check(w >= MIN_PHASE, "R7 high phase width", w, MIN_PHASE);
      if (w > max_idle_f) max_idle_f = w;
    end
    last_fall_f = $time;
  end

  always @(posedge out_f) begin
    int w;
    w = int'($time - last_fall_f);
    if (armed) check(w >= MIN_PHASE, "R7 low phase width", w, MIN_PHASE);
    last_rise_f = $time;
  end

  // Scoreboard monitor: measures the output period for each expected item
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t it;
        time  t1;
        int   per;
        it = exp_q[0];
        if (it.fall) begin
          @(posedge out_f); t1 = $time; @(posedge out_f);
        end else begin
          @(posedge out_r); t1 = $time; @(posedge out_r);
        end
        per = int'($time - t1);
        check(per == it.period, it.tag, per, it.period);
        void'(exp_q.pop_front());
      end
    end
  end

  // Driver: change select away from any edge, then queue expected clocks
  task automatic select_and_expect(input logic v, input string tag);
    logic was;
    int   per;
    was = sel;
    @(posedge clk0);
    #2.5;
    sel = v;
    max_idle_r = 0;
    max_idle_f = 0;
    #SETTLE;
    per = v ? CLK1_PERIOD : CLK_PERIOD;
    exp_q.push_back('{1'b0, per, tag});
    exp_q.push_back('{1'b1, per, "R7 falling variant period"});
    wait (exp_q.size() == 0);
    if (v != was) begin
      check(max_idle_r > MAX_NAT, "R4 parked low during handover", max_idle_r, MAX_NAT + 1);
      check(max_idle_f > MAX_NAT, "R7 parked high during handover", max_idle_f, MAX_NAT + 1);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R6: during reset both variants follow source 0
    repeat (3) @(posedge clk0);
    #2;
    check(out_r == 1'b1, "R6 reset follows clk0 high", int'(out_r), 1);
    check(out_f == 1'b1, "R6 R7 reset follows clk0 high", int'(out_f), 1);
    #5;
    check(out_r == 1'b0, "R6 reset follows clk0 low", int'(out_r), 0);
    check(out_f == 1'b0, "R6 R7 reset follows clk0 low", int'(out_f), 0);

    @(negedge clk0);
    #1 rst_n = 1'b1;
    #60;
    armed = 1'b1;

    select_and_expect(1'b0, "R6 post-reset source 0 period");
    select_and_expect(1'b1, "R2 source 1 period");
    select_and_expect(1'b0, "R1 source 0 period");

    // R5: short select pulse inside the active phase of source 0
    @(posedge clk0);
    #1 sel = 1'b1;
    #2 sel = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk0);
      #2;
      check(out_r == 1'b1, "R5 pulse ignored, high", int'(out_r), 1);
      #5;
      check(out_r == 1'b0, "R5 pulse ignored, low", int'(out_r), 0);
    end
    select_and_expect(1'b0, "R5 source 0 kept after pulse");

    // R5: short select pulse inside the active phase of source 1
    select_and_expect(1'b1, "R2 source 1 period again");
    @(posedge clk1);
    #1 sel = 1'b0;
    #3 sel = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk1);
      #2;
      check(out_r == 1'b1, "R5 pulse ignored on source 1, high", int'(out_r), 1);
      #7;
      check(out_r == 1'b0, "R5 pulse ignored on source 1, low", int'(out_r), 0);
    end
    select_and_expect(1'b1, "R5 source 1 kept after pulse");

    // R3: switchovers at random times
    for (int i = 0; i < 20; i++) begin
      #($urandom_range(80, 140));
      @(posedge clk0);
      #2.5;
      sel = ~sel;
    end
    select_and_expect(sel, "R3 final source period after random switching");
    select_and_expect(~sel, "R3 last switchover period");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule